// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to one of four 16-bit segment bases. Each base is first scaled by sixteen, which means four zero bits are appended below it. The block holds the four segment registers: extra, code, stack and data. A single write port loads any one of them per cycle.

With each request the caller supplies an access kind, an optional override request and the offset. The access kind covers instruction fetch, stack-pointer access, base-pointer access, general data, string source and string destination. The block chooses the segment from fixed and default rules, applying the override only where the rules allow one. It returns the address, the segment it used, and a flag that says whether an override was refused. All of these outputs come one clock after the request.

Segment numbering, used by both the write port and the override field: 0 = extra, 1 = code, 2 = stack, 3 = data. Access kind codes: 0 = fetch, 1 = stack pointer, 2 = base pointer, 3 = data, 4 = string source, 5 = string destination, 6 and 7 = treated as data.

Top module: `physaddr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid`, `out_addr`, `out_seg_used` and `out_ovr_ignored` are 0 and all four segment registers read 0. A data request with offset 0055h right after reset therefore yields 00055h.
- R2: A request accepted with `req_valid` high produces `out_valid` high on the next clock. In that cycle `out_addr` equals (segment × 16 + offset) for the selected segment.
- R3: With code segment 348Ah and a fetch at offset 4214h, the address is 38AB4h. With stack segment 4000h and a stack-pointer access at offset 9F20h, the address is 49F20h.
- R4: The sum wraps modulo 2^20. Data segment FFFFh with offset FFFFh gives 0FFEFh.
- R5: Kind 0 (fetch) always uses segment 1 (code), whatever the override inputs are.
- R6: Kind 1 (stack pointer) always uses segment 2 (stack), whatever the override inputs are.
- R7: Kind 2 (base pointer) uses segment 2 (stack) unless `req_ovr_en` is high, in which case it uses `req_ovr_seg`.
- R8: Kinds 3, 4, 6 and 7 use segment 3 (data) unless `req_ovr_en` is high, in which case they use `req_ovr_seg`.
- R9: Kind 5 (string destination) always uses segment 0 (extra), whatever the override inputs are.
- R10: `out_ovr_ignored` is high in the cycle after a valid request of kind 0, 1 or 5 that had `req_ovr_en` high. In every other cycle it is low.
- R11: A segment write is used by requests issued in the cycle after the write. A request issued in the same cycle as the write still sees the old value.
- R12: In the cycle after `req_valid` was low, `out_valid` is low and `out_addr` and `out_seg_used` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Load one segment register |
| seg_wr_sel | input | 2 | Segment to load (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 3 | Access kind code |
| req_ovr_en | input | 1 | Override segment requested |
| req_ovr_seg | input | 2 | Override segment number |
| req_offset | input | 16 | Offset within the segment |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_addr | output | 20 | Physical address |
| out_seg_used | output | 2 | Segment that was applied |
| out_ovr_ignored | output | 1 | Override was refused for this request |

## Verification
A segment write and an address request can occur in the same cycle, and they can even target the same register. The bench provokes this in two ways. A directed case loads a new code segment while a fetch is issued, then fetches again in the next cycle. The random phase also mixes writes and requests freely. The bench's model applies each write only after it has computed the expected address for that cycle. A correct result is therefore the old base for the same-cycle request and the new base for the following one.

// File: rtl/physaddr_pkg.sv
package physaddr_pkg;

  localparam int NUM_SEG   = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [2:0] {
    ACC_FETCH   = 3'd0,
    ACC_SPTR    = 3'd1,
    ACC_BPTR    = 3'd2,
    ACC_DATA    = 3'd3,
    ACC_STR_SRC = 3'd4,
    ACC_STR_DST = 3'd5,
    ACC_RSV6    = 3'd6,
    ACC_RSV7    = 3'd7
  } acc_kind_e;

  // Kinds whose segment is fixed and cannot be overridden
  function automatic logic kind_is_fixed(acc_kind_e k);
    logic fx;
    case (k)
      ACC_FETCH, ACC_SPTR, ACC_STR_DST: fx = 1'b1;
      default:                          fx = 1'b0;
    endcase
    return fx;
  endfunction

  function automatic seg_id_e kind_default_seg(acc_kind_e k);
    seg_id_e s;
    case (k)
      ACC_FETCH:        s = SEG_CODE;
      ACC_SPTR,
      ACC_BPTR:         s = SEG_STACK;
      ACC_STR_DST:      s = SEG_EXTRA;
      default:          s = SEG_DATA;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [SEG_W-1:0]           wr_data,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic             ld;
    logic [SEG_W-1:0] d;

    always_comb begin
      ld = wr_en && (wr_sel == SEL_W'(g));
      d  = ld ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (ld) begin
        seg_q[g] <= d;
      end
    end
  end

endmodule

// File: rtl/seg_selector.sv
module seg_selector
  import physaddr_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       ovr_en,
  input  logic [1:0] ovr_seg,
  output logic [1:0] seg_sel,
  output logic       ovr_refused
);

  acc_kind_e k;
  logic      fixed;

  always_comb begin
    k           = acc_kind_e'(kind);
    fixed       = kind_is_fixed(k);
    ovr_refused = ovr_en && fixed;
    if (ovr_en && !fixed) begin
      seg_sel = ovr_seg;
    end else begin
      seg_sel = kind_default_seg(k);
    end
  end

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFS_W-1:0] ofs,
  output logic [PA_W-1:0]  pa
);

  logic [PA_W-1:0] base;
  logic [PA_W-1:0] ofs_ext;

  always_comb begin
    base    = {seg, {SHIFT{1'b0}}};
    ofs_ext = PA_W'(ofs);
    pa      = base + ofs_ext;   // carry out of PA_W discarded: wraps
  end

endmodule

// File: rtl/physaddr_gen.sv
module physaddr_gen
  import physaddr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [1:0]        seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_ovr_en,
  input  logic [1:0]        req_ovr_seg,
  input  logic [OFS_W-1:0]  req_offset,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_addr,
  output logic [1:0]        out_seg_used,
  output logic              out_ovr_ignored
);

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [1:0]                    sel;
  logic                          refused;
  logic [PA_W-1:0]               pa;

  logic              valid_d;
  logic [PA_W-1:0]   addr_d;
  logic [1:0]        seg_d;
  logic              ign_d;
  logic              load_en;

  seg_regfile #(.SEG_W(SEG_W), .NSEG(NUM_SEG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .seg_q   (seg_q)
  );

  seg_selector u_sel (
    .kind        (req_kind),
    .ovr_en      (req_ovr_en),
    .ovr_seg     (req_ovr_seg),
    .seg_sel     (sel),
    .ovr_refused (refused)
  );

  addr_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
    .seg (seg_q[sel]),
    .ofs (req_offset),
    .pa  (pa)
  );

  // next-state
  always_comb begin
    load_en = req_valid;
    valid_d = req_valid;
    ign_d   = req_valid && refused;
    addr_d  = load_en ? pa  : out_addr;
    seg_d   = load_en ? sel : out_seg_used;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_ovr_ignored <= 1'b0;
    end else begin
      out_valid       <= valid_d;
      out_ovr_ignored <= ign_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr     <= '0;
      out_seg_used <= '0;
    end else if (load_en) begin
      out_addr     <= addr_d;
      out_seg_used <= seg_d;
    end
  end

endmodule

// File: rtl/physaddr_gen_chk.sv
module physaddr_gen_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      req_kind,
  input logic            req_ovr_en,
  input logic [1:0]      req_ovr_seg,
  input logic            out_valid,
  input logic [PA_W-1:0] out_addr,
  input logic [1:0]      out_seg_used,
  input logic            out_ovr_ignored
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);  // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_seg_used)));  // R12

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0) |=> (out_seg_used == 2'd1));  // R5

  AST_SPTR_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1) |=> (out_seg_used == 2'd2));  // R6

  AST_DST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd5) |=> (out_seg_used == 2'd0));  // R9

  AST_OVR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ovr_en && (req_kind == 3'd2 || req_kind >= 3'd3) && req_kind != 3'd5)
      |=> (out_seg_used == $past(req_ovr_seg)));  // R8

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ovr_en && (req_kind == 3'd0 || req_kind == 3'd1 || req_kind == 3'd5))
      |=> out_ovr_ignored);  // R10

  AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_ovr_en) |=> !out_ovr_ignored);  // R10

endmodule

bind physaddr_gen physaddr_gen_chk #(.PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_kind        (req_kind),
  .req_ovr_en      (req_ovr_en),
  .req_ovr_seg     (req_ovr_seg),
  .out_valid       (out_valid),
  .out_addr        (out_addr),
  .out_seg_used    (out_seg_used),
  .out_ovr_ignored (out_ovr_ignored)
);

// File: tb/physaddr_gen_test.sv
module physaddr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic        req_ovr_en;
  logic [1:0]  req_ovr_seg;
  logic [15:0] req_offset;
  logic        out_valid;
  logic [19:0] out_addr;
  logic [1:0]  out_seg_used;
  logic        out_ovr_ignored;

  always #10 clk = ~clk;  // 50 MHz

  physaddr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_ovr_en(req_ovr_en),
    .req_ovr_seg(req_ovr_seg), .req_offset(req_offset),
    .out_valid(out_valid), .out_addr(out_addr), .out_seg_used(out_seg_used),
    .out_ovr_ignored(out_ovr_ignored)
  );

  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] m_seg [4];
  logic [19:0] e_addr;
  logic [1:0]  e_seg;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic is_fixed(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd5);
  endfunction

  function automatic logic [1:0] pick(input logic [2:0] k, input logic oe,
                                      input logic [1:0] os);
    if (k == 3'd0) return 2'd1;
    if (k == 3'd1) return 2'd2;
    if (k == 3'd5) return 2'd0;
    if (oe)        return os;
    if (k == 3'd2) return 2'd2;
    return 2'd3;
  endfunction

  // drive at negedge, check shortly after the next posedge
  task automatic step(input string req, input logic we, input logic [1:0] ws,
                      input logic [15:0] wd, input logic rv, input logic [2:0] k,
                      input logic oe, input logic [1:0] os, input logic [15:0] of);
    logic [1:0] s;
    seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
    req_valid = rv; req_kind = k; req_ovr_en = oe; req_ovr_seg = os; req_offset = of;
    s = pick(k, oe, os);
    if (rv) begin
      e_seg  = s;
      e_addr = {m_seg[s], 4'h0} + {4'h0, of};
    end
    @(posedge clk);
    if (we) m_seg[ws] = wd;
    #2;
    chk(req, "valid",   {31'd0, out_valid},       {31'd0, rv});
    chk(req, "addr",    {12'd0, out_addr},        {12'd0, e_addr});
    chk(req, "seg",     {30'd0, out_seg_used},    {30'd0, e_seg});
    chk(req, "ignored", {31'd0, out_ovr_ignored}, {31'd0, rv && oe && is_fixed(k)});
    @(negedge clk);
  endtask

  task automatic wr(input string req, input logic [1:0] ws, input logic [15:0] wd);
    step(req, 1'b1, ws, wd, 1'b0, 3'd0, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic rq(input string req, input logic [2:0] k, input logic oe,
                    input logic [1:0] os, input logic [15:0] of);
    step(req, 1'b0, 2'd0, 16'h0, 1'b1, k, oe, os, of);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    req_valid = 0; req_kind = 0; req_ovr_en = 0; req_ovr_seg = 0; req_offset = 0;
    for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
    e_addr = '0; e_seg = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid",   {31'd0, out_valid},       32'd0);
    chk("R1", "addr",    {12'd0, out_addr},        32'd0);
    chk("R1", "seg",     {30'd0, out_seg_used},    32'd0);
    chk("R1", "ignored", {31'd0, out_ovr_ignored}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rq("R1", 3'd3, 1'b0, 2'd0, 16'h0055);          // expects 00055h

    // R3 worked examples, R12 hold during writes
    wr("R12", 2'd1, 16'h348A);
    rq("R3", 3'd0, 1'b0, 2'd0, 16'h4214);          // 38AB4h
    wr("R12", 2'd2, 16'h4000);
    rq("R3", 3'd1, 1'b0, 2'd0, 16'h9F20);          // 49F20h
    chk("R3", "example1", {12'd0, e_addr}, 32'h49F20);

    // R5 R6 R10 fixed kinds refuse override
    rq("R5", 3'd0, 1'b1, 2'd3, 16'h0010);
    rq("R6", 3'd1, 1'b1, 2'd0, 16'h0020);
    // R7 base pointer
    wr("R7", 2'd3, 16'h2000);
    rq("R7", 3'd2, 1'b0, 2'd0, 16'h0100);
    wr("R7", 2'd0, 16'h7000);
    rq("R7", 3'd2, 1'b1, 2'd0, 16'h0100);
    // R8 data kinds
    rq("R8", 3'd3, 1'b0, 2'd0, 16'hABCD);
    rq("R8", 3'd4, 1'b1, 2'd1, 16'h0004);
    rq("R8", 3'd6, 1'b0, 2'd0, 16'h0006);
    rq("R8", 3'd7, 1'b1, 2'd2, 16'h0007);
    // R9 string destination
    rq("R9", 3'd5, 1'b0, 2'd0, 16'h0042);
    rq("R9", 3'd5, 1'b1, 2'd3, 16'h0042);
    // R4 wrap
    wr("R4", 2'd3, 16'hFFFF);
    rq("R4", 3'd3, 1'b0, 2'd0, 16'hFFFF);
    chk("R4", "wrap", {12'd0, e_addr}, 32'h0FFEF);
    // R11 write and request in same cycle on the same register
    step("R11", 1'b1, 2'd1, 16'h1111, 1'b1, 3'd0, 1'b0, 2'd0, 16'h0001);
    chk("R11", "old base", {12'd0, out_addr}, 32'h348A1);
    rq("R11", 3'd0, 1'b0, 2'd0, 16'h0001);
    chk("R11", "new base", {12'd0, out_addr}, 32'h11111);
    // R12 idle hold
    step("R12", 1'b0, 2'd0, 16'h0, 1'b0, 3'd3, 1'b1, 2'd1, 16'h9999);

    // R2 random mix of writes and requests
    for (int n = 0; n < 3000; n++) begin
      step("R2", 1'($urandom % 3 == 0), 2'($urandom), 16'($urandom),
           1'($urandom % 4 != 0), 3'($urandom), 1'($urandom),
           2'($urandom), 16'($urandom));
    end

    summary();
    $finish;
  end

endmodule